// File: doc/BRIEF.md
# Packet Receive Queue with Register Read-Out

This block takes in 32-bit words from an AXI4-Stream source. Packet boundaries are marked by TLAST. The block keeps every received word in a data store and records the word count of each finished packet in a separate length queue. A processor drains the packets through a small set of register reads:

1. Read the occupancy to see whether anything is waiting.
2. Read the byte length of the oldest packet. This also opens that packet for reading.
3. Pop its words one register read at a time.

The block keeps track of how far the processor has read into the open packet. It raises a single-cycle event when the processor breaks the read order, when a packet arrives, and when a keyed flush of the receive side has finished. An interrupt controller placed next to the block collects these events.

The register port is a plain strobe interface. A read or write is taken on any clock edge where its strobe is high. Read data and events are registered and appear one cycle after the access.

Top module: `pktrx_rxq`

## Requirements
- R1: After reset, `s_tready` is 1, `evt_o` is 0, `reg_rdata` is 0, and the occupancy reads 0.
- R2: When a word with `s_tlast` high is accepted, `evt_o` bit 26 pulses in the following cycle.
- R3: A read at offset 0x1C returns the number of stored words that belong to completed packets. It never counts the words of a packet that is still arriving, and it never exceeds the data store depth.
- R4: A read at offset 0x24 returns four times the word count of the oldest unopened packet and makes that packet the open one. If no packet is complete, the read returns 0.
- R5: A read at offset 0x20 returns the next word of the open packet, in arrival order, and removes that word.
- R6: A read at offset 0x20 while the occupancy is 0 returns 0, removes nothing and pulses `evt_o` bit 29.
- R7: A read at offset 0x20 when the open packet is used up but the occupancy is nonzero returns 0, removes nothing and pulses `evt_o` bit 30.
- R8: A read at offset 0x24 while words of the open packet remain pulses `evt_o` bit 31. The remaining words are discarded, and the read still returns the next packet's length.
- R9: Writing 0xA5 at offset 0x18 empties the data store, the length queue and any partial packet. `evt_o` bit 23 pulses two cycles after the write, and `s_tready` is 0 in the cycle between. A write of any other value has no effect.
- R10: `s_tready` is 0 whenever the data store is full or the length queue is full.
- R11: Read data and events become visible in the cycle after the access. Each event lasts exactly one cycle, and at most one of bits 31, 30 and 29 is set at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | 32 | Stream word |
| s_tvalid | input | 1 | Stream word valid |
| s_tlast | input | 1 | Last word of the packet |
| s_tready | output | 1 | Block can accept a word |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the read |
| evt_o | output | 32 | Single-cycle event pulses at bits 23, 26, 29, 30, 31 |

## Verification
The assertions assume three things about the inputs:
- `reg_rd` and `reg_wr` are never high in the same cycle.
- No packet is longer than the data store. A longer packet would fill the store before its TLAST arrives and stall forever.
- The stream source holds `s_tvalid` and its word steady until the word is accepted.

The stimulus respects these limits. Random packets are 1 to 6 words long and are sent only when the bench's own model shows room for the whole packet. The directed fill test sends exactly one store-sized packet. Register accesses are issued one at a time, with a gap between them.

// File: rtl/pktrx_pkg.sv
package pktrx_pkg;
    localparam logic [5:0]  RA_FLUSH  = 6'h18;
    localparam logic [5:0]  RA_OCC    = 6'h1C;
    localparam logic [5:0]  RA_DATA   = 6'h20;
    localparam logic [5:0]  RA_LEN    = 6'h24;
    localparam logic [31:0] FLUSH_KEY = 32'h0000_00A5;

    localparam int EV_FLUSHED   = 23;
    localparam int EV_PKT       = 26;
    localparam int EV_UNDERRUN  = 29;
    localparam int EV_OVERREAD  = 30;
    localparam int EV_UNDERREAD = 31;
endpackage

// File: rtl/pktrx_fifo.sv
// Power-of-two circular store; pop_n may remove several entries in one cycle.
module pktrx_fifo #(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic [AW:0]   pop_n,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [AW:0]   cnt;
    } ptr_t;

    logic [W-1:0] mem [DEPTH];
    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (clr) begin
            ptr_d = '0;
        end else begin
            if (push) ptr_d.wr = ptr_q.wr + AW'(1);
            ptr_d.rd  = ptr_q.rd + pop_n[AW-1:0];
            ptr_d.cnt = ptr_q.cnt + (AW+1)'(push) - pop_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem[ptr_q.wr] <= din;
    end

    assign dout  = mem[ptr_q.rd];
    assign empty = (ptr_q.cnt == '0);
    assign full  = (ptr_q.cnt == (AW+1)'(DEPTH));
endmodule

// File: rtl/pktrx_rxq.sv
module pktrx_rxq
    import pktrx_pkg::*;
#(
    parameter int DATA_AW = 5,
    parameter int LEN_AW  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] s_tdata,
    input  logic        s_tvalid,
    input  logic        s_tlast,
    output logic        s_tready,
    input  logic        reg_rd,
    input  logic        reg_wr,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic [31:0] evt_o
);
    localparam int CW = DATA_AW + 1;

    typedef struct packed {
        logic [CW-1:0] cur;    // words of the packet still arriving
        logic [CW-1:0] occ;    // words of complete packets held
        logic [CW-1:0] rem;    // unread words of the open packet
        logic          pend;   // flush requested, applied next cycle
        logic [31:0]   rdata;
        logic [31:0]   evt;
    } st_t;

    st_t st_d, st_q;

    logic [31:0]     d_dout;
    logic            d_empty, d_full;
    logic [CW:0]     d_pad;
    logic [CW-1:0]   d_popn;
    logic [CW-1:0]   l_dout;
    logic            l_empty, l_full;
    logic [LEN_AW:0] l_popn;
    logic            accept;
    logic [CW-1:0]   add_w, sub_w;

    assign s_tready = !d_full && !l_full && !st_q.pend;
    assign accept   = s_tvalid && s_tready;
    assign d_pad    = {1'b0, d_popn};

    always_comb begin
        st_d      = st_q;
        st_d.evt  = '0;
        d_popn    = '0;
        l_popn    = '0;
        add_w     = '0;
        sub_w     = '0;
        st_d.pend = reg_wr && (reg_addr == RA_FLUSH) && (reg_wdata == FLUSH_KEY)
                    && !st_q.pend;
        if (st_q.pend) begin
            st_d.cur  = '0;
            st_d.occ  = '0;
            st_d.rem  = '0;
            st_d.pend = 1'b0;
            st_d.evt[EV_FLUSHED] = 1'b1;
        end else begin
            if (accept) begin
                if (s_tlast) begin
                    st_d.cur = '0;
                    add_w    = st_q.cur + CW'(1);
                    st_d.evt[EV_PKT] = 1'b1;
                end else begin
                    st_d.cur = st_q.cur + CW'(1);
                end
            end
            if (reg_rd) begin
                case (reg_addr)
                    RA_OCC: st_d.rdata = 32'(st_q.occ);
                    RA_LEN: begin
                        if (st_q.rem != '0) begin
                            st_d.evt[EV_UNDERREAD] = 1'b1;
                            d_popn = st_q.rem;
                        end
                        if (!l_empty) begin
                            st_d.rdata = 32'(l_dout) << 2;
                            st_d.rem   = l_dout;
                            l_popn     = (LEN_AW+1)'(1);
                        end else begin
                            st_d.rdata = '0;
                            st_d.rem   = '0;
                        end
                    end
                    RA_DATA: begin
                        if (st_q.occ == '0) begin
                            st_d.evt[EV_UNDERRUN] = 1'b1;
                            st_d.rdata = '0;
                        end else if (st_q.rem == '0 || d_empty) begin
                            st_d.evt[EV_OVERREAD] = 1'b1;
                            st_d.rdata = '0;
                        end else begin
                            st_d.rdata = d_dout;
                            d_popn     = CW'(1);
                            st_d.rem   = st_q.rem - CW'(1);
                        end
                    end
                    default: st_d.rdata = '0;
                endcase
            end
            sub_w    = d_popn;
            st_d.occ = st_q.occ + add_w - sub_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pktrx_fifo #(.W(32), .AW(DATA_AW)) u_data (
        .clk(clk), .rst_n(rst_n), .clr(st_q.pend),
        .push(accept), .din(s_tdata), .pop_n(d_pad[DATA_AW:0]),
        .dout(d_dout), .empty(d_empty), .full(d_full)
    );

    pktrx_fifo #(.W(CW), .AW(LEN_AW)) u_len (
        .clk(clk), .rst_n(rst_n), .clr(st_q.pend),
        .push(accept && s_tlast), .din(st_q.cur + CW'(1)), .pop_n(l_popn),
        .dout(l_dout), .empty(l_empty), .full(l_full)
    );

    assign reg_rdata = st_q.rdata;
    assign evt_o     = st_q.evt;
endmodule

// File: rtl/pktrx_rxq_chk.sv
module pktrx_rxq_chk
    import pktrx_pkg::*;
#(
    parameter int DATA_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_tvalid,
    input logic              s_tready,
    input logic              s_tlast,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [5:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       evt_o,
    input logic [DATA_AW:0]  occ,
    input logic              dfull
);
    localparam int DEPTH = 1 << DATA_AW;

    assert_pkt_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o[EV_PKT] |-> $past(s_tvalid && s_tready && s_tlast));

    assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= (DATA_AW+1)'(DEPTH));

    assert_underrun_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o[EV_UNDERRUN] |-> $past(reg_rd && reg_addr == RA_DATA));

    assert_overread_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o[EV_OVERREAD] |-> $past(reg_rd && reg_addr == RA_DATA));

    assert_underread_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o[EV_UNDERREAD] |-> $past(reg_rd && reg_addr == RA_LEN));

    assert_flush_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o[EV_FLUSHED] |-> $past(reg_wr && reg_addr == RA_FLUSH && reg_wdata == FLUSH_KEY, 2));

    assert_full_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dfull |-> !s_tready);

    assert_err_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(evt_o[31:29]));
endmodule

bind pktrx_rxq pktrx_rxq_chk #(.DATA_AW(DATA_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .s_tlast(s_tlast), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .evt_o(evt_o), .occ(st_q.occ), .dfull(d_full)
);

// File: tb/pktrx_rxq_bench.sv
module pktrx_rxq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 32;
    localparam int LQ    = 8;
    localparam logic [5:0] A_FL = 6'h18, A_OCC = 6'h1C, A_DAT = 6'h20, A_LEN = 6'h24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] s_tdata = '0;
    logic        s_tvalid = 1'b0, s_tlast = 1'b0;
    logic        s_tready;
    logic        reg_rd = 1'b0, reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, evt_o;

    int n_chk = 0, n_fail = 0;
    logic [31:0] m_words[$];
    int          m_lens[$];
    int          m_rem = 0;
    logic [31:0] partial[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pktrx_rxq u_pktrx_rxq (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tlast(s_tlast), .s_tready(s_tready), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_o(evt_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ev(input int b);
        return 32'(1) << b;
    endfunction

    // model of a register read: returns expected data and event vector
    function automatic void model_read(input logic [5:0] a, output logic [31:0] d,
                                       output logic [31:0] e);
        d = '0; e = '0;
        if (a == A_OCC) begin
            d = 32'(m_words.size());
        end else if (a == A_LEN) begin
            if (m_rem > 0) begin
                e = ev(31);
                repeat (m_rem) void'(m_words.pop_front());
            end
            m_rem = 0;
            if (m_lens.size() > 0) begin
                m_rem = m_lens.pop_front();
                d = 32'(m_rem * 4);
            end
        end else if (a == A_DAT) begin
            if (m_words.size() == 0)  e = ev(29);
            else if (m_rem == 0)      e = ev(30);
            else begin
                d = m_words.pop_front();
                m_rem--;
            end
        end
    endfunction

    task automatic do_read(input logic [5:0] a, input string req);
        logic [31:0] ed, ee;
        model_read(a, ed, ee);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
        check({req, " rdata"}, reg_rdata, ed);
        check({req, " evt"}, evt_o, ee);
    endtask

    task automatic send_word(input logic [31:0] w, input logic last);
        @(negedge clk);
        s_tvalid = 1'b1; s_tdata = w; s_tlast = last;
        while (!s_tready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic send_pkt(input int n, input logic close);
        for (int i = 0; i < n; i++) begin
            logic [31:0] w;
            w = $urandom;
            partial.push_back(w);
            send_word(w, close && (i == n - 1));
        end
        @(negedge clk);
        s_tvalid = 1'b0; s_tlast = 1'b0;
        if (close) begin
            check("R2 packet event", evt_o, ev(26));
            m_lens.push_back(partial.size());
            while (partial.size() > 0) m_words.push_back(partial.pop_front());
        end
    endtask

    task automatic do_write(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic flush();
        do_write(A_FL, 32'hA5);
        check("R9 ready low during flush", 32'(s_tready), 32'd0);
        @(posedge clk);
        @(negedge clk);
        check("R9 flush event", evt_o, ev(23));
        m_words.delete(); m_lens.delete(); partial.delete(); m_rem = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready", 32'(s_tready), 32'd1);
        check("R1 evt", evt_o, 32'd0);
        check("R1 rdata", reg_rdata, 32'd0);
        do_read(A_OCC, "R1 R3 occupancy");

        // R6 and R11: empty data read, then the event must be gone
        do_read(A_DAT, "R6 underrun");
        @(negedge clk);
        check("R11 single-cycle event", evt_o, 32'd0);
        do_read(A_LEN, "R4 empty length");

        // R3: partial packet not counted
        send_pkt(3, 1'b0);
        do_read(A_OCC, "R3 partial excluded");
        for (int i = 0; i < 2; i++) send_word(32'hC0DE_0000 + 32'(i), 1'b0);
        send_word(32'hC0DE_00FF, 1'b1);
        @(negedge clk);
        s_tvalid = 1'b0; s_tlast = 1'b0;
        check("R2 packet event", evt_o, ev(26));
        partial.push_back(32'hC0DE_0000); partial.push_back(32'hC0DE_0001);
        partial.push_back(32'hC0DE_00FF);
        m_lens.push_back(6);
        while (partial.size() > 0) m_words.push_back(partial.pop_front());
        do_read(A_OCC, "R3 after close");

        // R7: over-read with another packet waiting
        send_pkt(2, 1'b1);
        do_read(A_LEN, "R4 length");
        for (int i = 0; i < 6; i++) do_read(A_DAT, "R5 data");
        do_read(A_DAT, "R7 over-read");
        do_read(A_OCC, "R7 nothing removed");

        // R8: under-read discards the rest
        send_pkt(4, 1'b1);
        do_read(A_LEN, "R4 length");
        do_read(A_DAT, "R5 data");
        do_read(A_LEN, "R8 under-read");
        do_read(A_OCC, "R8 occupancy after skip");
        do_read(A_DAT, "R5 data after skip");

        // R9: wrong key ignored, right key flushes
        do_write(A_FL, 32'h5A);
        @(posedge clk);
        @(negedge clk);
        check("R9 wrong key no event", evt_o, 32'd0);
        do_read(A_OCC, "R9 wrong key ignored");
        flush();
        do_read(A_OCC, "R9 flushed occupancy");
        do_read(A_LEN, "R9 flushed length");

        // R10: length queue full, then data store full
        for (int i = 0; i < LQ; i++) send_pkt(1, 1'b1);
        check("R10 length queue full", 32'(s_tready), 32'd0);
        do_read(A_LEN, "R4 length");
        do_read(A_DAT, "R5 data");
        @(negedge clk);
        check("R10 ready again", 32'(s_tready), 32'd1);
        flush();
        send_pkt(DEPTH, 1'b1);
        check("R10 data store full", 32'(s_tready), 32'd0);
        do_read(A_OCC, "R3 full occupancy");
        flush();

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 4) begin
                int n;
                n = int'($urandom_range(1, 6));
                if (m_words.size() + n <= DEPTH && m_lens.size() < LQ) send_pkt(n, 1'b1);
            end else if (op < 5) begin
                do_read(A_OCC, "R3 random occupancy");
            end else if (op < 7) begin
                do_read(A_LEN, "R4 R8 random length");
            end else begin
                do_read(A_DAT, "R5 R6 R7 random data");
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule